// File: doc/BRIEF.md
# Test-Port Configuration Register Slave

This block is the configuration end of a receive PHY. Software reaches it through a slow, bit-banged test port: a test clock, a test enable, an 8-bit data bus, a test clear and an 8-bit read-back bus. One shared 8-bit bus carries both the register address (the "test code") and the data. Which one it carries depends on the level of the test enable and on the direction of the test-clock edge. A falling edge with the enable high takes the bus as the new code. A rising edge with the enable low writes the bus into the register that code selects.

The slave keeps a small register file: one clock-lane control register, one settle-time control register, and one high-speed receive control register for each of the four data lanes. The lane registers keep only a 7-bit frequency-range code. The port pins are sampled in the block's own fast clock domain through two-flop synchronizers, and edges of the test clock are found by comparing successive samples. The read-back bus always shows the register that the current code selects. Writing to code 0x00 puts the block back into normal operation.

Top module: `tport_reg_slave`

## Requirements
- R1: A falling edge of the test clock while the test enable is 1 latches the data input as the current code. The read-back bus then shows the register at that code, with no write needed.
- R2: A rising edge of the test clock while the test enable is 0 writes the data input into the register selected by the current code.
- R3: A rising edge with the enable at 1, a falling edge with the enable at 0, and data-bus changes with no test-clock edge change neither the code nor any register.
- R4: Code 0x34 (clock-lane control) and code 0x75 (settle-time control) each hold a full 8-bit value and read it back unchanged.
- R5: Codes 0x44, 0x54, 0x84 and 0x94 are the receive controls of data lanes 0 to 3. Each one keeps only data bits 7:1 as a frequency-range code, and its bit 0 reads as 0.
- R6: Any other code, including 0x00, reads back as 0x00. Writes to such a code change no register.
- R7: While the test clear is 1, all registers and the current code go to zero and the normal flag goes to 1.
- R8: The normal flag is 1 after reset. It drops to 0 when a nonzero code is latched. It returns to 1 when a write lands while the current code is 0x00.
- R9: After reset the read-back bus is 0x00 and the normal flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tp_clk | input | 1 | Test clock, idles high |
| tp_en | input | 1 | Test enable: 1 = code phase, 0 = data phase |
| tp_din | input | 8 | Shared code / data bus |
| tp_clr | input | 1 | Test clear, active high |
| tp_dout | output | 8 | Register selected by the current code |
| normal_o | output | 1 | Normal-operation flag |

## Verification
A change on any test-port pin passes two synchronizer flops and one edge-detect flop. The code or register update therefore happens on the third clock edge after the pin changes, and the read-back register shows the result on the fourth. A clear reaches the read-back bus on the fourth edge after the pin rises. The driver holds every pin phase for six clock cycles and pushes the expected read-back and flag values only after that hold. The monitor then compares them at the next falling clock edge, once the result is settled. Checks that a stimulus must be ignored read back the exposed register in the middle of the transaction, after the edge that must not act and before the edge that may.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int DW    = 8;
  localparam int NLANE = 4;

  localparam logic [DW-1:0] CODE_NORMAL = 8'h00;
  localparam logic [DW-1:0] CODE_CKLANE = 8'h34;
  localparam logic [DW-1:0] CODE_SETTLE = 8'h75;
  localparam logic [NLANE-1:0][DW-1:0] CODE_LANE = {8'h94, 8'h84, 8'h54, 8'h44};

  function automatic logic is_lane_code(logic [DW-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NLANE; i++) begin
      if (c == CODE_LANE[i]) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic is_known_code(logic [DW-1:0] c);
    return is_lane_code(c) || (c == CODE_CKLANE) || (c == CODE_SETTLE);
  endfunction
endpackage

// File: rtl/tport_sync.sv
module tport_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q;
  logic [W-1:0] stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= RST_VAL;
      stg2_q <= RST_VAL;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;
endmodule

// File: rtl/tport_edge.sv
module tport_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tck_i,
  output logic fall_o,
  output logic rise_o
);
  logic prev_q;

  // previous sample resets high: the test clock idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= tck_i;
  end

  assign fall_o = prev_q & ~tck_i;
  assign rise_o = ~prev_q & tck_i;
endmodule

// File: rtl/tport_regfile.sv
module tport_regfile
  import tport_pkg::*;
#(
  parameter int NL = NLANE,
  parameter int W  = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         fall_i,
  input  logic         rise_i,
  input  logic         en_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] code_o,
  output logic [W-1:0] dout_o,
  output logic         normal_o
);
  localparam int LW = W - 1;

  logic         latch_c, write_c;
  logic [W-1:0] code_q, code_d;
  logic         code_en;
  logic [W-1:0] ck_q, ck_d, st_q, st_d;
  logic         ck_en, st_en;
  logic         nrm_q, nrm_d, nrm_en;
  logic [LW-1:0] lane_q [NL];
  logic [LW-1:0] lane_d;
  logic [NL-1:0] lane_en;
  logic [W-1:0] rd_c;
  logic [W-1:0] dout_q;

  // next-state logic for code, full-width registers and flag
  always_comb begin
    latch_c = fall_i & en_i;
    write_c = rise_i & ~en_i;

    code_en = clr_i | latch_c;
    code_d  = clr_i ? '0 : din_i;

    ck_en = clr_i | (write_c && code_q == CODE_CKLANE);
    ck_d  = clr_i ? '0 : din_i;
    st_en = clr_i | (write_c && code_q == CODE_SETTLE);
    st_d  = clr_i ? '0 : din_i;
    lane_d = clr_i ? '0 : din_i[W-1:1];

    nrm_en = clr_i | (latch_c && din_i != CODE_NORMAL)
                   | (write_c && code_q == CODE_NORMAL);
    nrm_d  = clr_i | (write_c && code_q == CODE_NORMAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ck_q   <= '0;
      st_q   <= '0;
      nrm_q  <= 1'b1;
    end else begin
      if (code_en) code_q <= code_d;
      if (ck_en)   ck_q   <= ck_d;
      if (st_en)   st_q   <= st_d;
      if (nrm_en)  nrm_q  <= nrm_d;
    end
  end

  // one receive-control register per data lane
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign lane_en[g] = clr_i | (write_c && code_q == CODE_LANE[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q[g] <= '0;
      else if (lane_en[g]) lane_q[g] <= lane_d;
    end
  end

  // read-back selection
  always_comb begin
    rd_c = '0;
    if (code_q == CODE_CKLANE) rd_c = ck_q;
    if (code_q == CODE_SETTLE) rd_c = st_q;
    for (int i = 0; i < NL; i++) begin
      if (code_q == CODE_LANE[i]) rd_c = {lane_q[i], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= rd_c;
  end

  assign code_o   = code_q;
  assign dout_o   = dout_q;
  assign normal_o = nrm_q;
endmodule

// File: rtl/tport_reg_slave.sv
module tport_reg_slave
  import tport_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tp_clk,
  input  logic          tp_en,
  input  logic [DW-1:0] tp_din,
  input  logic          tp_clr,
  output logic [DW-1:0] tp_dout,
  output logic          normal_o
);
  localparam int BW = DW + 2;

  logic [1:0]    rst_pipe_q;
  logic          rst_sync_n;
  logic [BW-1:0] port_s;
  logic          tck_s, ten_s, clr_s;
  logic [DW-1:0] tdin_s;
  logic          edge_fall, edge_rise;
  logic [DW-1:0] code_w;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tport_sync #(.W(BW), .RST_VAL({1'b1, {(BW-1){1'b0}}})) u_port_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({tp_clk, tp_en, tp_din}),
    .q_o   (port_s)
  );
  assign tck_s  = port_s[BW-1];
  assign ten_s  = port_s[BW-2];
  assign tdin_s = port_s[DW-1:0];

  tport_sync #(.W(1), .RST_VAL(1'b0)) u_clr_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (tp_clr),
    .q_o   (clr_s)
  );

  tport_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tck_i  (tck_s),
    .fall_o (edge_fall),
    .rise_o (edge_rise)
  );

  tport_regfile #(.NL(NLANE), .W(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr_i    (clr_s),
    .fall_i   (edge_fall),
    .rise_i   (edge_rise),
    .en_i     (ten_s),
    .din_i    (tdin_s),
    .code_o   (code_w),
    .dout_o   (tp_dout),
    .normal_o (normal_o)
  );
endmodule

// File: rtl/tport_reg_slave_chk.sv
module tport_reg_slave_chk
  import tport_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          clr_s,
  input logic          fall,
  input logic [DW-1:0] code,
  input logic [DW-1:0] dout,
  input logic          normal
);
  // R7: a held clear empties the read-back
  assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && $past(clr_s)) |=> (dout == '0));

  // R7: clear raises the normal flag
  assert_clr_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> normal);

  // R3: without a falling edge or clear the code stays put
  assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !clr_s) |=> $stable(code));

  // R6: unknown codes read back zero
  assert_unknown_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_known_code(code) |=> (dout == '0));

  // R5: lane registers read bit 0 as zero
  assert_lane_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_lane_code(code) |=> (dout[0] == 1'b0));
endmodule

bind tport_reg_slave tport_reg_slave_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .clr_s  (clr_s),
  .fall   (edge_fall),
  .code   (code_w),
  .dout   (tp_dout),
  .normal (normal_o)
);

// File: tb/test_tport_reg_slave.sv
module test_tport_reg_slave;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tp_clk, tp_en, tp_clr;
  logic [7:0] tp_din;
  logic [7:0] tp_dout;
  logic       normal_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    string      tag;
    logic [7:0] dout;
    logic       norm;
  } exp_t;

  exp_t sb_q[$];

  always #10 clk = ~clk;

  tport_reg_slave i_tport_reg_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .tp_clk   (tp_clk),
    .tp_en    (tp_en),
    .tp_din   (tp_din),
    .tp_clr   (tp_clr),
    .tp_dout  (tp_dout),
    .normal_o (normal_o)
  );

  task automatic hold(int n = 6);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_item(string tag, logic [7:0] d, logic nm);
    exp_t e;
    e.tag = tag; e.dout = d; e.norm = nm;
    sb_q.push_back(e);
  endtask

  task automatic xact(logic [7:0] code, logic [7:0] data);
    tp_en = 1'b1; tp_din = code; hold();
    tp_clk = 1'b0; hold();
    tp_en = 1'b0; tp_din = data; hold();
    tp_clk = 1'b1; hold();
  endtask

  // code only: the rising edge happens with enable high and must not write
  task automatic sel(logic [7:0] code);
    tp_en = 1'b1; tp_din = code; hold();
    tp_clk = 1'b0; hold();
    tp_clk = 1'b1; hold();
    tp_en = 1'b0; hold();
  endtask

  // monitor: compare one expected item per falling clock edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (tp_dout !== e.dout || normal_o !== e.norm) begin
        n_bad++;
        $display("FAIL %s: dout=%h normal=%b, expected dout=%h normal=%b",
                 e.tag, tp_dout, normal_o, e.dout, e.norm);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tp_clk = 1'b1; tp_en = 1'b0; tp_din = 8'h00; tp_clr = 1'b0;
    hold(4);
    rst_n = 1'b1;
    hold(10);
    expect_item("R9 reset state", 8'h00, 1'b1);

    xact(8'h34, 8'hA5);
    expect_item("R2 R4 clock-lane write", 8'hA5, 1'b0);
    xact(8'h75, 8'h04);
    expect_item("R4 settle write", 8'h04, 1'b0);

    for (int i = 0; i < 4; i++) begin
      logic [7:0] c, d;
      c = (i < 2) ? 8'h44 + 8'(i * 16) : 8'h84 + 8'((i - 2) * 16);
      d = 8'h11 + 8'(i * 34);
      xact(c, d);
      expect_item("R5 lane write drops bit 0", d & 8'hFE, 1'b0);
    end

    sel(8'h34);
    expect_item("R1 R3 code-only select keeps clock lane", 8'hA5, 1'b0);
    sel(8'h44);
    expect_item("R1 select lane 0", 8'h10, 1'b0);

    // falling edge with enable low: code must stay at lane 0
    tp_en = 1'b0; tp_din = 8'h84; hold();
    tp_clk = 1'b0; hold();
    expect_item("R3 falling edge with enable low ignored", 8'h10, 1'b0);
    tp_din = 8'h2C; hold();
    tp_clk = 1'b1; hold();
    expect_item("R2 write into still-selected lane 0", 8'h2C, 1'b0);

    tp_din = 8'hFF; hold();
    tp_din = 8'h00; hold();
    expect_item("R3 bus change without edge ignored", 8'h2C, 1'b0);

    xact(8'h55, 8'hFF);
    expect_item("R6 unknown code reads zero", 8'h00, 1'b0);
    sel(8'h34);
    expect_item("R6 clock lane untouched by unknown write", 8'hA5, 1'b0);
    sel(8'h75);
    expect_item("R6 settle untouched by unknown write", 8'h04, 1'b0);

    xact(8'h00, 8'h00);
    expect_item("R8 write at code 0x00 restores normal", 8'h00, 1'b1);
    sel(8'h84);
    expect_item("R8 nonzero code clears normal", 8'h54, 1'b0);

    tp_clr = 1'b1; hold();
    tp_clr = 1'b0; hold();
    expect_item("R7 clear zeroes code and sets normal", 8'h00, 1'b1);
    sel(8'h34);
    expect_item("R7 clock lane cleared", 8'h00, 1'b0);
    sel(8'h94);
    expect_item("R7 lane 3 cleared", 8'h00, 1'b0);

    xact(8'h94, 8'h81);
    expect_item("R5 lane 3 write after clear", 8'h80, 1'b0);

    hold(4);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule